// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Occupancy Thresholds

This block is a first-in first-out buffer of 256 words of 9 bits. The producer side has its own clock and the consumer side has its own clock. The two clocks may be unrelated, or they may be the same net. A write needs two enables, one active low and one active high, and both must be asserted. A read needs two active-low enables, and both must be asserted. A read word is captured into an output register. An output-enable input qualifies that register's value on the data port, and the port shows zero when the enable is low.

Four status outputs describe the buffer. Empty and almost-empty are computed in the read clock domain. Full and almost-full are computed in the write clock domain. Pointers move between the domains as Gray codes through two-flop synchronisers. The two thresholds are held in a pair of offset registers, and each offset is 7 after reset. While the configuration input is high, qualified writes load the offsets from the low 8 data bits, and qualified reads return the offsets on the output register. Both follow a two-step sequence that wraps around. The buffer contents and pointers are left untouched during these accesses.

Top module: `dual_clk_fifo_pf`

## Requirements
- R1: With `cfg_load` low, a word is stored on a `wr_clk` rising edge when `wr_en_n`=0 and `wr_en`=1. It is moved into the output register on a `rd_clk` rising edge when `rd_en_a_n`=0 and `rd_en_b_n`=0. Words leave in the order they entered.
- R2: No word is stored when `wr_en_n`=1 or `wr_en`=0.
- R3: No word is removed and the output register holds its value when either read enable is 1.
- R4: A qualified write while `full`=1 is dropped. The stored words and their order are unchanged.
- R5: A qualified read while `empty`=1 is dropped. The output register and the read position are unchanged.
- R6: `full`=1 exactly when 256 words are held. `empty`=1 when no word is held, as seen in the read domain after the write pointer has crossed over, which takes at most 3 read-clock edges.
- R7: `almost_empty`=1 when the stored count is at or below the empty offset. `almost_full`=1 when the free count is at or below the full offset.
- R8: With `cfg_load` high, qualified writes load `wr_data[7:0]` into the empty offset first, then into the full offset, then wrap back to the empty offset. No word is added to the buffer.
- R9: With `cfg_load` high, qualified reads put `{1'b0, offset}` into the output register, the empty offset first and then the full offset, wrapping in the same way. The read position does not move.
- R10: When `out_en`=1, `rd_data` shows the output register and `rd_valid`=1. When `out_en`=0, `rd_data`=0 and `rd_valid`=0.
- R11: While `rst_n`=0, the block is emptied (`empty`=1, `almost_empty`=1, `full`=0, `almost_full`=0). Both offsets return to 7, both offset sequences return to the empty offset, and the output register is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| rst_n | input | 1 | Asynchronous reset, active low, for both domains |
| wr_en_n | input | 1 | Write enable, active low |
| wr_en | input | 1 | Write enable, active high |
| cfg_load | input | 1 | Steers qualified accesses to the offset registers |
| wr_data | input | 9 | Write data |
| rd_en_a_n | input | 1 | First read enable, active low |
| rd_en_b_n | input | 1 | Second read enable, active low |
| out_en | input | 1 | Output qualifier |
| rd_data | output | 9 | Output register value, or zero when not enabled |
| rd_valid | output | 1 | High when `rd_data` is enabled |
| empty | output | 1 | No words held (read domain) |
| almost_empty | output | 1 | Count at or below the empty offset (read domain) |
| full | output | 1 | 256 words held (write domain) |
| almost_full | output | 1 | Free space at or below the full offset (write domain) |

## Verification
The assertions check several properties on every clock edge. A write attempted while full, or a read attempted while empty, leaves the pointer unchanged. Each Gray pointer changes at most one bit per edge. The exact flags imply their almost flags. Every offset access advances its sequence, and a readback never moves the read position. Only the bench scenarios can show the rest. These cover the order of the data across a full fill and drain, the exact threshold counts at the default and loaded offsets, the order of offset loading and readback, and the effect of reset on offsets that were already reprogrammed.

// File: rtl/dcf_pkg.sv
`timescale 1ns/1ps
package dcf_pkg;
  // Which offset register the next configuration access targets.
  typedef enum logic {
    SEL_AE = 1'b0,
    SEL_AF = 1'b1
  } offs_sel_e;

  function automatic offs_sel_e next_sel(input offs_sel_e s);
    return (s == SEL_AE) ? SEL_AF : SEL_AE;
  endfunction
endpackage

// File: rtl/dcf_gray_sync.sv
`timescale 1ns/1ps
module dcf_gray_sync #(
  parameter int W      = 9,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) stg[s] <= '0;
          else        stg[s] <= d;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) stg[s] <= '0;
          else        stg[s] <= stg[s-1];
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/dcf_ram.sv
`timescale 1ns/1ps
module dcf_ram #(
  parameter int DW = 9,
  parameter int AW = 8
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge wclk)
    if (we) mem[waddr] <= wdata;

  assign rdata = mem[raddr];
endmodule

// File: rtl/dcf_wr_ctl.sv
`timescale 1ns/1ps
module dcf_wr_ctl import dcf_pkg::*; #(
  parameter int DW        = 9,
  parameter int AW        = 8,
  parameter int OFFS_INIT = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en_n,
  input  logic          wr_en,
  input  logic          load,
  input  logic [DW-1:0] wdata,
  input  logic [AW:0]   rgray_sync,
  output logic [AW:0]   wgray,
  output logic [AW:0]   wbin,
  output logic [AW-1:0] waddr,
  output logic          push,
  output logic          ld_wr,
  output offs_sel_e     ld_sel,
  output logic          full,
  output logic          almost_full,
  output logic [AW-1:0] ae_offs,
  output logic [AW-1:0] af_offs
);
  localparam int          PW    = AW + 1;
  localparam logic [PW-1:0] DEPTH = PW'(1) << AW;

  function automatic logic [PW-1:0] bin2gray(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] gray2bin(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  // Words held, as seen by the writer (never under-reports).
  function automatic logic [PW-1:0] held(input logic [PW-1:0] w, input logic [PW-1:0] r);
    return w - r;
  endfunction

  logic          qual;
  logic [PW-1:0] rbin_sync;
  logic [PW-1:0] count;
  logic [PW-1:0] room;
  logic [PW-1:0] wbin_nxt;
  logic          unused_hi;

  assign qual      = !wr_en_n && wr_en;
  assign ld_wr     = qual && load;
  assign push      = qual && !load && !full;
  assign rbin_sync = gray2bin(rgray_sync);
  assign count     = held(wbin, rbin_sync);
  assign room      = DEPTH - count;
  assign full        = (count == DEPTH);
  assign almost_full = ({1'b0, af_offs} >= room);
  assign wbin_nxt  = wbin + PW'(push);
  assign waddr     = wbin[AW-1:0];
  assign unused_hi = ^wdata[DW-1:AW];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wbin  <= '0;
      wgray <= '0;
    end else begin
      wbin  <= wbin_nxt;
      wgray <= bin2gray(wbin_nxt);
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ae_offs <= AW'(OFFS_INIT);
      af_offs <= AW'(OFFS_INIT);
      ld_sel  <= SEL_AE;
    end else if (ld_wr) begin
      if (ld_sel == SEL_AE) ae_offs <= wdata[AW-1:0];
      else                  af_offs <= wdata[AW-1:0];
      ld_sel <= next_sel(ld_sel);
    end
endmodule

// File: rtl/dcf_rd_ctl.sv
`timescale 1ns/1ps
module dcf_rd_ctl import dcf_pkg::*; #(
  parameter int DW = 9,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_en_a_n,
  input  logic          rd_en_b_n,
  input  logic          load,
  input  logic [AW:0]   wgray_sync,
  input  logic [DW-1:0] ram_rdata,
  input  logic [AW-1:0] ae_offs,
  input  logic [AW-1:0] af_offs,
  output logic [AW:0]   rgray,
  output logic [AW:0]   rbin,
  output logic [AW-1:0] raddr,
  output logic          pop,
  output logic          rb_fire,
  output offs_sel_e     rb_sel,
  output logic [DW-1:0] rd_q,
  output logic          empty,
  output logic          almost_empty
);
  localparam int PW = AW + 1;

  function automatic logic [PW-1:0] bin2gray(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] gray2bin(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  // Words available, as seen by the reader (never over-reports).
  function automatic logic [PW-1:0] avail(input logic [PW-1:0] w, input logic [PW-1:0] r);
    return w - r;
  endfunction

  logic          qual;
  logic [PW-1:0] wbin_sync;
  logic [PW-1:0] count;
  logic [PW-1:0] rbin_nxt;
  logic [AW-1:0] rb_val;

  assign qual         = !rd_en_a_n && !rd_en_b_n;
  assign pop          = qual && !load && !empty;
  assign rb_fire      = qual && load;
  assign wbin_sync    = gray2bin(wgray_sync);
  assign count        = avail(wbin_sync, rbin);
  assign empty        = (count == '0);
  assign almost_empty = ({1'b0, ae_offs} >= count);
  assign rbin_nxt     = rbin + PW'(pop);
  assign raddr        = rbin[AW-1:0];
  assign rb_val       = (rb_sel == SEL_AE) ? ae_offs : af_offs;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rbin  <= '0;
      rgray <= '0;
    end else begin
      rbin  <= rbin_nxt;
      rgray <= bin2gray(rbin_nxt);
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rd_q   <= '0;
      rb_sel <= SEL_AE;
    end else if (pop) begin
      rd_q <= ram_rdata;
    end else if (rb_fire) begin
      rd_q   <= DW'(rb_val);
      rb_sel <= next_sel(rb_sel);
    end
endmodule

// File: rtl/dual_clk_fifo_pf.sv
`timescale 1ns/1ps
module dual_clk_fifo_pf import dcf_pkg::*; #(
  parameter int DATA_W    = 9,
  parameter int ADDR_W    = 8,
  parameter int OFFS_INIT = 7,
  parameter int SYNC_STG  = 2
) (
  input  logic              wr_clk,
  input  logic              rd_clk,
  input  logic              rst_n,
  input  logic              wr_en_n,
  input  logic              wr_en,
  input  logic              cfg_load,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en_a_n,
  input  logic              rd_en_b_n,
  input  logic              out_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              empty,
  output logic              almost_empty,
  output logic              full,
  output logic              almost_full
);
  localparam int PW = ADDR_W + 1;

  // Named internal events, exposed for the bound checker.
  logic [PW-1:0]     wgray, wbin, rgray, rbin;
  logic [PW-1:0]     wgray_s, rgray_s;
  logic [ADDR_W-1:0] waddr, raddr;
  logic [ADDR_W-1:0] ae_offs, af_offs;
  logic [DATA_W-1:0] ram_rdata, rd_q;
  logic              push, pop, ld_wr, rb_fire;
  offs_sel_e         ld_sel, rb_sel;

  dcf_wr_ctl #(.DW(DATA_W), .AW(ADDR_W), .OFFS_INIT(OFFS_INIT)) u_wr (
    .clk(wr_clk), .rst_n(rst_n), .wr_en_n(wr_en_n), .wr_en(wr_en),
    .load(cfg_load), .wdata(wr_data), .rgray_sync(rgray_s),
    .wgray(wgray), .wbin(wbin), .waddr(waddr), .push(push),
    .ld_wr(ld_wr), .ld_sel(ld_sel), .full(full), .almost_full(almost_full),
    .ae_offs(ae_offs), .af_offs(af_offs)
  );

  dcf_gray_sync #(.W(PW), .STAGES(SYNC_STG)) u_w2r (
    .clk(rd_clk), .rst_n(rst_n), .d(wgray), .q(wgray_s)
  );

  dcf_gray_sync #(.W(PW), .STAGES(SYNC_STG)) u_r2w (
    .clk(wr_clk), .rst_n(rst_n), .d(rgray), .q(rgray_s)
  );

  dcf_ram #(.DW(DATA_W), .AW(ADDR_W)) u_ram (
    .wclk(wr_clk), .we(push), .waddr(waddr), .wdata(wr_data),
    .raddr(raddr), .rdata(ram_rdata)
  );

  dcf_rd_ctl #(.DW(DATA_W), .AW(ADDR_W)) u_rd (
    .clk(rd_clk), .rst_n(rst_n), .rd_en_a_n(rd_en_a_n), .rd_en_b_n(rd_en_b_n),
    .load(cfg_load), .wgray_sync(wgray_s), .ram_rdata(ram_rdata),
    .ae_offs(ae_offs), .af_offs(af_offs), .rgray(rgray), .rbin(rbin),
    .raddr(raddr), .pop(pop), .rb_fire(rb_fire), .rb_sel(rb_sel),
    .rd_q(rd_q), .empty(empty), .almost_empty(almost_empty)
  );

  assign rd_data  = out_en ? rd_q : '0;
  assign rd_valid = out_en;
endmodule

// File: rtl/dual_clk_fifo_pf_chk.sv
`timescale 1ns/1ps
module dual_clk_fifo_pf_chk #(
  parameter int DW = 9,
  parameter int AW = 8
) (
  input logic          wr_clk,
  input logic          rd_clk,
  input logic          rst_n,
  input logic          wr_en_n,
  input logic          wr_en,
  input logic          cfg_load,
  input logic          rd_en_a_n,
  input logic          rd_en_b_n,
  input logic          empty,
  input logic          almost_empty,
  input logic          full,
  input logic          almost_full,
  input logic [AW:0]   wbin,
  input logic [AW:0]   rbin,
  input logic [AW:0]   wgray,
  input logic [AW:0]   rgray,
  input logic [DW-1:0] rd_q,
  input logic          ld_wr,
  input logic          ld_sel,
  input logic          rb_fire,
  input logic          rb_sel
);
  logic wq, rq;
  assign wq = !wr_en_n && wr_en;
  assign rq = !rd_en_a_n && !rd_en_b_n;

  a_r4_no_overflow: assert property (@(posedge wr_clk) disable iff (!rst_n)
    (full && wq && !cfg_load) |=> $stable(wbin));

  a_r5_no_underflow: assert property (@(posedge rd_clk) disable iff (!rst_n)
    (empty && rq && !cfg_load) |=> ($stable(rbin) && $stable(rd_q)));

  a_r6_full_in_af: assert property (@(posedge wr_clk) disable iff (!rst_n)
    full |-> almost_full);

  a_r6_empty_in_ae: assert property (@(posedge rd_clk) disable iff (!rst_n)
    empty |-> almost_empty);

  a_r1_wgray_step: assert property (@(posedge wr_clk) disable iff (!rst_n)
    $onehot0(wgray ^ $past(wgray)));

  a_r1_rgray_step: assert property (@(posedge rd_clk) disable iff (!rst_n)
    $onehot0(rgray ^ $past(rgray)));

  a_r8_load_advances: assert property (@(posedge wr_clk) disable iff (!rst_n)
    ld_wr |=> (ld_sel != $past(ld_sel)));

  a_r9_readback_holds_ptr: assert property (@(posedge rd_clk) disable iff (!rst_n)
    rb_fire |=> ($stable(rbin) && (rb_sel != $past(rb_sel))));
endmodule

bind dual_clk_fifo_pf dual_clk_fifo_pf_chk #(.DW(DATA_W), .AW(ADDR_W)) u_chk (
  .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n),
  .wr_en_n(wr_en_n), .wr_en(wr_en), .cfg_load(cfg_load),
  .rd_en_a_n(rd_en_a_n), .rd_en_b_n(rd_en_b_n),
  .empty(empty), .almost_empty(almost_empty), .full(full), .almost_full(almost_full),
  .wbin(wbin), .rbin(rbin), .wgray(wgray), .rgray(rgray), .rd_q(rd_q),
  .ld_wr(ld_wr), .ld_sel(ld_sel), .rb_fire(rb_fire), .rb_sel(rb_sel)
);

// File: tb/dual_clk_fifo_pf_bench.sv
`timescale 1ns/1ps
module dual_clk_fifo_pf_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en_n, wr_en, cfg_load, rd_en_a_n, rd_en_b_n, out_en;
  logic [8:0] wr_data;
  logic [8:0] rd_data;
  logic       rd_valid, empty, almost_empty, full, almost_full;

  int n_chk  = 0;
  int n_fail = 0;

  // Reference model
  int         q[$];
  logic [8:0] exp_q;
  logic [7:0] ae_m, af_m;
  bit         wsel_m, rsel_m;

  always #2.5 clk = ~clk;

  dual_clk_fifo_pf u_dual_clk_fifo_pf (
    .wr_clk(clk), .rd_clk(clk), .rst_n(rst_n),
    .wr_en_n(wr_en_n), .wr_en(wr_en), .cfg_load(cfg_load), .wr_data(wr_data),
    .rd_en_a_n(rd_en_a_n), .rd_en_b_n(rd_en_b_n), .out_en(out_en),
    .rd_data(rd_data), .rd_valid(rd_valid), .empty(empty),
    .almost_empty(almost_empty), .full(full), .almost_full(almost_full)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic settle();
    repeat (4) cyc();
  endtask

  function automatic logic [8:0] pat(input int i);
    return 9'((i * 37 + 11) & 'h1FF);
  endfunction

  task automatic wr(input logic [8:0] v, input bit en_n = 1'b0, input bit en = 1'b1);
    wr_en_n = en_n; wr_en = en; wr_data = v;
    cyc();
    wr_en_n = 1'b1; wr_en = 1'b0;
    if (!en_n && en) begin
      if (cfg_load) begin
        if (!wsel_m) ae_m = v[7:0]; else af_m = v[7:0];
        wsel_m = !wsel_m;
      end else if (q.size() < 256) q.push_back(int'(v));
    end
  endtask

  task automatic rd(input string req, input bit a_n = 1'b0, input bit b_n = 1'b0);
    rd_en_a_n = a_n; rd_en_b_n = b_n;
    cyc();
    rd_en_a_n = 1'b1; rd_en_b_n = 1'b1;
    if (!a_n && !b_n) begin
      if (cfg_load) begin
        exp_q = {1'b0, (rsel_m ? af_m : ae_m)};
        rsel_m = !rsel_m;
      end else if (q.size() > 0) exp_q = 9'(q.pop_front());
    end
    check(req, rd_data, exp_q);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) cyc();
    check("R11 empty in reset", empty, 1);
    check("R11 full in reset", full, 0);
    rst_n = 1'b1;
    cyc();
    q.delete(); exp_q = '0; ae_m = 8'd7; af_m = 8'd7; wsel_m = 0; rsel_m = 0;
  endtask

  task automatic t_reset_state();
    do_reset();
    check("R11 empty", empty, 1);
    check("R11 almost_empty", almost_empty, 1);
    check("R11 full", full, 0);
    check("R11 almost_full", almost_full, 0);
    check("R11 rd_data cleared", rd_data, 0);
    cfg_load = 1'b1;
    rd("R11 R9 default empty offset");
    rd("R11 R9 default full offset");
    cfg_load = 1'b0;
    settle();
    check("R9 readback leaves empty", empty, 1);
  endtask

  task automatic t_basic();
    for (int i = 0; i < 5; i++) wr(pat(i));
    settle();
    check("R6 not empty", empty, 0);
    check("R7 five held is almost empty", almost_empty, 1);
    for (int i = 0; i < 5; i++) rd("R1 order");
    check("R6 empty after drain", empty, 1);
  endtask

  task automatic t_gating();
    wr(9'h0F0, 1'b1, 1'b1);
    wr(9'h0F1, 1'b0, 1'b0);
    wr(9'h0F2, 1'b1, 1'b0);
    settle();
    check("R2 disabled writes store nothing", empty, 1);
    rd("R5 read on empty holds output");
    wr(9'h1A1);
    settle();
    rd("R3 read with b high", 1'b0, 1'b1);
    rd("R3 read with a high", 1'b1, 1'b0);
    check("R3 word still held", empty, 0);
    rd("R1 gated word then read");
    check("R6 empty", empty, 1);
  endtask

  task automatic t_fill();
    settle();
    for (int i = 0; i < 248; i++) wr(pat(i + 100));
    check("R7 eight free not almost full", almost_full, 0);
    wr(pat(348));
    check("R7 seven free is almost full", almost_full, 1);
    for (int i = 249; i < 256; i++) wr(pat(i + 100));
    check("R6 full at 256", full, 1);
    wr(9'h1AA);
    check("R4 still full", full, 1);
    settle();
    for (int i = 0; i < 256; i++) begin
      if (q.size() == 8) check("R7 eight held not almost empty", almost_empty, 0);
      if (q.size() == 7) check("R7 seven held almost empty", almost_empty, 1);
      rd("R4 R1 drain order, dropped word absent");
    end
    check("R6 empty after full drain", empty, 1);
    rd("R5 read on empty holds last word");
    settle();
    check("R6 not full after drain", full, 0);
  endtask

  task automatic t_offsets();
    cfg_load = 1'b1;
    wr(9'h103);
    wr(9'h005);
    rd("R9 readback empty offset");
    rd("R9 readback full offset");
    rd("R9 readback wraps");
    cfg_load = 1'b0;
    settle();
    check("R8 load writes store no word", empty, 1);
    for (int i = 0; i < 3; i++) wr(pat(i + 500));
    settle();
    check("R8 R7 three held at offset 3", almost_empty, 1);
    wr(pat(503));
    settle();
    check("R8 R7 four held above offset 3", almost_empty, 0);
    for (int i = 0; i < 4; i++) rd("R8 data intact after loads");
    settle();
    for (int i = 0; i < 250; i++) wr(pat(i + 700));
    check("R8 R7 six free above offset 5", almost_full, 0);
    wr(pat(950));
    check("R8 R7 five free at offset 5", almost_full, 1);
  endtask

  task automatic t_out_en();
    do_reset();
    wr(9'h155);
    settle();
    rd("R1 word before gating");
    out_en = 1'b0;
    #1;
    check("R10 rd_data zero when disabled", rd_data, 0);
    check("R10 rd_valid low", rd_valid, 0);
    out_en = 1'b1;
    #1;
    check("R10 rd_data restored", rd_data, 9'h155);
    check("R10 rd_valid high", rd_valid, 1);
  endtask

  task automatic t_reset_restore();
    cfg_load = 1'b1;
    wr(9'h011);
    wr(9'h012);
    wr(9'h013);
    cfg_load = 1'b0;
    do_reset();
    cfg_load = 1'b1;
    wr(9'h002);
    rd("R11 sequence restarts at empty offset");
    rd("R11 full offset restored to 7");
    cfg_load = 1'b0;
  endtask

  initial begin
    rst_n = 1'b1; wr_en_n = 1'b1; wr_en = 1'b0; cfg_load = 1'b0;
    rd_en_a_n = 1'b1; rd_en_b_n = 1'b1; out_en = 1'b1; wr_data = '0;
    exp_q = '0; ae_m = 8'd7; af_m = 8'd7; wsel_m = 0; rsel_m = 0;
    t_reset_state();
    t_basic();
    t_gating();
    t_fill();
    t_offsets();
    t_out_en();
    t_reset_restore();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule